// File: doc/BRIEF.md
# Nonvolatile Command Unlock Sequence Detector

This block sits beside the control logic of an asynchronous-style SRAM port and watches every access the host makes. Each chip-enable falling edge reaches it as a single-cycle strobe, already synchronised to the local clock. On that strobe the block samples the 13-bit address and the write-enable level. A host asks for a nonvolatile operation by issuing six reads at fixed addresses, uninterrupted and in a fixed order. The first five addresses are common to both commands, and the sixth one decides whether a STORE or a RECALL is wanted.

When a complete sequence is accepted, the block raises a one-cycle request pulse for the chosen operation. It also raises a busy level that locks the port. The busy level stays high until the execution engine reports completion. Any write, any read at an unexpected address, or a repeated strobe on the same step throws away the progress made so far. The output-enable level takes no part in detection and is not an input.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: The prefix advances one step per read strobe (we_n = 1) only when the address equals the next expected value, in this order: 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0.
- R2: After all five prefix steps, a read strobe at 0x0F0F makes store_req high for exactly the one cycle after that strobe's clock edge. A read strobe at 0x0F0E does the same on recall_req. The two requests are never high together.
- R3: After the full prefix, a read strobe at any sixth address other than 0x0F0F or 0x0F0E produces no request and aborts the sequence.
- R4: A write strobe (we_n = 0) at any step aborts the sequence back to idle, including a write to 0x0000, and produces no request.
- R5: A read strobe at an unexpected address aborts the sequence. If that address is 0x0000, the strobe counts as the first step of a new sequence; otherwise the sequence returns to idle.
- R6: A second strobe at the address of the step just accepted (a double strobe) aborts the sequence.
- R7: busy rises together with the request pulse. It stays high until the cycle after op_done is sampled high. Strobes seen while busy is high are ignored. After busy falls, detection starts from idle.
- R8: Address and we_n changes without a strobe have no effect on the sequence.
- R9: Synchronous active-low reset clears busy and both requests and returns the sequence to idle.
- R10: op_done has no effect while busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_fall | input | 1 | Single-cycle strobe marking a chip-enable falling edge |
| addr | input | 13 | Address sampled on the strobe |
| we_n | input | 1 | Write-enable level sampled on the strobe, 1 = read |
| op_done | input | 1 | Completion of the requested store or recall |
| store_req | output | 1 | One-cycle STORE request |
| recall_req | output | 1 | One-cycle RECALL request |
| busy | output | 1 | Operation in progress, port disabled |

## Verification
The hardest situations to reach from the ports are those deep in the sequence: a wrong sixth address, or a write or double strobe on step four or five. Uniform random addresses almost never get beyond the first step. For that reason the random stimulus favours the next expected address, so that long runs of correct steps are common. Random aborts are then mixed into those runs, and directed cases cover reset during a partial sequence and strobes arriving while busy is high.

// File: rtl/nvcmd_pkg.sv
// Package: shared widths, key addresses and command encoding for the
// nonvolatile command unlock detector.
package nvcmd_pkg;
    localparam int ADDR_W     = 13;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } cmd_e;

    localparam addr_t STORE_KEY  = 13'h0F0F;
    localparam addr_t RECALL_KEY = 13'h0F0E;

    // Expected address of shared prefix step idx (0-based).
    function automatic addr_t prefix_key(input int idx);
        case (idx)
            0:       return 13'h0000;
            1:       return 13'h1555;
            2:       return 13'h0AAA;
            3:       return 13'h1FFF;
            default: return 13'h10F0;
        endcase
    endfunction
endpackage

// File: rtl/nvcmd_key_match.sv
// Module: nvcmd_key_match
// Compares the sampled address with every key the sequence can expect.
// Assumes the prefix keys are distinct from each other and from the
// final keys. Purely combinational.
module nvcmd_key_match
    import nvcmd_pkg::*;
(
    input  addr_t addr,
    input  step_t prog,
    output logic  hit_next,
    output logic  hit_first,
    output cmd_e  final_cmd
);
    logic [PREFIX_LEN-1:0] key_hit;

    // One comparator per prefix step.
    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_key
        assign key_hit[g] = (addr == prefix_key(g));
    end

    // Select the comparator for the step currently expected.
    always_comb begin
        hit_next = 1'b0;
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (prog == step_t'(i)) hit_next = key_hit[i];
        end
    end

    assign hit_first = key_hit[0];

    // Decode the sixth address into a command.
    always_comb begin
        if (addr == STORE_KEY)       final_cmd = CMD_STORE;
        else if (addr == RECALL_KEY) final_cmd = CMD_RECALL;
        else                         final_cmd = CMD_NONE;
    end
endmodule

// File: rtl/nvcmd_step_tracker.sv
// Module: nvcmd_step_tracker
// Holds the count of accepted prefix steps and decides on each strobe
// whether to advance, restart, abort or fire a command. Assumes ce_fall is
// a single-cycle synchronous strobe and busy comes from the op controller.
module nvcmd_step_tracker
    import nvcmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_fall,
    input  logic we_n,
    input  logic busy,
    input  logic hit_next,
    input  logic hit_first,
    input  cmd_e final_cmd,
    output step_t prog,
    output cmd_e fire
);
    step_t prog_nx;

    // Next-step decision for the strobe of this cycle.
    always_comb begin
        prog_nx = prog;
        fire    = CMD_NONE;
        if (ce_fall && !busy) begin
            if (!we_n) begin
                prog_nx = '0;
            end else if (prog == step_t'(PREFIX_LEN) && final_cmd != CMD_NONE) begin
                fire    = final_cmd;
                prog_nx = '0;
            end else if (hit_next) begin
                prog_nx = prog + step_t'(1);
            end else if (hit_first) begin
                prog_nx = step_t'(1);
            end else begin
                prog_nx = '0;
            end
        end
    end

    // Step register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prog <= '0;
        else        prog <= prog_nx;
    end

    AST_PROG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        prog <= step_t'(PREFIX_LEN)); // R1
    AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_fall && !we_n && !busy) |=> (prog == '0)); // R4
    AST_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (prog == '0)); // R7
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_fall |=> $stable(prog)); // R8
endmodule

// File: rtl/nvcmd_op_ctrl.sv
// Module: nvcmd_op_ctrl
// Turns a fired command into a one-cycle request pulse and holds busy
// until the execution engine reports completion. Assumes fire is only
// raised while busy is low.
module nvcmd_op_ctrl
    import nvcmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_e fire,
    input  logic op_done,
    output logic store_req,
    output logic recall_req,
    output logic busy
);
    // Register request pulses and the busy level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
            busy       <= 1'b0;
        end else begin
            store_req  <= (fire == CMD_STORE);
            recall_req <= (fire == CMD_RECALL);
            if (fire != CMD_NONE) busy <= 1'b1;
            else if (op_done)     busy <= 1'b0;
        end
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req)); // R2
    AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req); // R2
    AST_RECALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req); // R2
    AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> busy); // R7
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done) |=> busy); // R7
    AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (store_req || recall_req)); // R7
endmodule

// File: rtl/nvcmd_seq_detect.sv
// Module: nvcmd_seq_detect (top)
// Watches strobed SRAM accesses for the six-read unlock sequence and
// issues a STORE or RECALL request, then holds the port disabled until
// op_done. Assumes ce_fall is already synchronised to clk.
module nvcmd_seq_detect
    import nvcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_fall,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we_n,
    input  logic              op_done,
    output logic              store_req,
    output logic              recall_req,
    output logic              busy
);
    step_t prog;
    logic  hit_next;
    logic  hit_first;
    cmd_e  final_cmd;
    cmd_e  fire;

    nvcmd_key_match u_match (
        .addr      (addr),
        .prog      (prog),
        .hit_next  (hit_next),
        .hit_first (hit_first),
        .final_cmd (final_cmd)
    );

    nvcmd_step_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_fall   (ce_fall),
        .we_n      (we_n),
        .busy      (busy),
        .hit_next  (hit_next),
        .hit_first (hit_first),
        .final_cmd (final_cmd),
        .prog      (prog),
        .fire      (fire)
    );

    nvcmd_op_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .op_done    (op_done),
        .store_req  (store_req),
        .recall_req (recall_req),
        .busy       (busy)
    );
endmodule

// File: tb/tb_nvcmd_seq_detect.sv
`timescale 1ns/1ps
module tb_nvcmd_seq_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_fall = 1'b0;
    logic [12:0] addr = '0;
    logic        we_n = 1'b1;
    logic        op_done = 1'b0;
    logic        store_req, recall_req, busy;

    int tests = 0;
    int fails = 0;
    int m_prog = 0;
    bit m_busy = 1'b0;

    nvcmd_seq_detect dut (
        .clk(clk), .rst_n(rst_n), .ce_fall(ce_fall), .addr(addr), .we_n(we_n),
        .op_done(op_done), .store_req(store_req), .recall_req(recall_req), .busy(busy)
    );

    always #2 clk = ~clk;

    function automatic logic [12:0] kv(input int i);
        case (i)
            0: return 13'h0000;
            1: return 13'h1555;
            2: return 13'h0AAA;
            3: return 13'h1FFF;
            default: return 13'h10F0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_outs(input string tag, input bit es, input bit er);
        chk(tag, "store_req", store_req, es);
        chk(tag, "recall_req", recall_req, er);
        chk(tag, "busy", busy, m_busy);
    endtask

    // One strobed access; expected values come from the requirement model.
    task automatic access(input logic [12:0] a, input bit w_n, input string tag);
        bit es = 1'b0;
        bit er = 1'b0;
        @(negedge clk);
        ce_fall = 1'b1; addr = a; we_n = w_n;
        if (!m_busy) begin
            if (!w_n) m_prog = 0;
            else if (m_prog == 5 && a == 13'h0F0F) begin es = 1; m_busy = 1; m_prog = 0; end
            else if (m_prog == 5 && a == 13'h0F0E) begin er = 1; m_busy = 1; m_prog = 0; end
            else if (m_prog < 5 && a == kv(m_prog)) m_prog++;
            else if (a == 13'h0000) m_prog = 1;
            else m_prog = 0;
        end
        @(negedge clk);
        ce_fall = 1'b0; we_n = 1'b1;
        check_outs(tag, es, er);
    endtask

    task automatic finish_op(input string tag);
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        m_busy = 1'b0;
        check_outs(tag, 1'b0, 1'b0);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_prog = 0; m_busy = 1'b0;
        check_outs(tag, 1'b0, 1'b0);
    endtask

    task automatic run_prefix(input string tag);
        for (int i = 0; i < 5; i++) access(kv(i), 1'b1, tag);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_outs("R9", 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1 R2: full store and full recall
        run_prefix("R1");
        access(13'h0F0F, 1'b1, "R2");
        finish_op("R7");
        run_prefix("R1");
        access(13'h0F0E, 1'b1, "R2");
        finish_op("R7");

        // R3: wrong sixth address, then a late store key does nothing
        run_prefix("R3");
        access(13'h0F0D, 1'b1, "R3");
        access(13'h0F0F, 1'b1, "R3");

        // R4: write inside the sequence, also a write to 0x0000
        for (int i = 0; i < 3; i++) access(kv(i), 1'b1, "R4");
        access(kv(3), 1'b0, "R4");
        access(kv(4), 1'b1, "R4");
        access(13'h0F0F, 1'b1, "R4");
        access(kv(0), 1'b1, "R4");
        access(kv(0), 1'b0, "R4");
        for (int i = 1; i < 5; i++) access(kv(i), 1'b1, "R4");
        access(13'h0F0F, 1'b1, "R4");

        // R5: restart on 0x0000 mid-sequence
        access(kv(0), 1'b1, "R5");
        access(kv(1), 1'b1, "R5");
        access(kv(0), 1'b1, "R5");
        for (int i = 1; i < 5; i++) access(kv(i), 1'b1, "R5");
        access(13'h0F0F, 1'b1, "R5");
        finish_op("R5");

        // R6: double strobe on step two
        access(kv(0), 1'b1, "R6");
        access(kv(1), 1'b1, "R6");
        access(kv(1), 1'b1, "R6");
        for (int i = 2; i < 5; i++) access(kv(i), 1'b1, "R6");
        access(13'h0F0E, 1'b1, "R6");

        // R7: strobes ignored while busy, fresh start afterwards
        run_prefix("R7");
        access(13'h0F0F, 1'b1, "R7");
        run_prefix("R7");
        access(13'h0F0E, 1'b1, "R7");
        access(kv(0), 1'b0, "R7");
        finish_op("R7");
        run_prefix("R7");
        access(13'h0F0E, 1'b1, "R7");
        finish_op("R7");

        // R8: address and we_n wiggle without strobe
        access(kv(0), 1'b1, "R8");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); addr = 13'h0F0F; we_n = 1'b0;
        end
        @(negedge clk); we_n = 1'b1;
        for (int i = 1; i < 5; i++) access(kv(i), 1'b1, "R8");
        access(13'h0F0F, 1'b1, "R8");
        finish_op("R8");

        // R10: op_done while idle
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        check_outs("R10", 1'b0, 1'b0);
        run_prefix("R10");
        access(13'h0F0E, 1'b1, "R10");
        finish_op("R10");

        // R9: reset mid-sequence and while busy
        for (int i = 0; i < 3; i++) access(kv(i), 1'b1, "R9");
        do_reset("R9");
        access(kv(3), 1'b1, "R9");
        access(kv(4), 1'b1, "R9");
        access(13'h0F0F, 1'b1, "R9");
        run_prefix("R9");
        access(13'h0F0F, 1'b1, "R9");
        do_reset("R9");

        // Random phase, biased toward the next expected step
        begin
            int unsigned seed_v = $urandom(32'h5EED);
            if (seed_v == 0) m_prog = 0;
        end
        for (int n = 0; n < 4000; n++) begin
            int unsigned r = $urandom % 10;
            logic [12:0] a;
            if (r < 5) begin
                if (m_prog < 5) a = kv(m_prog);
                else a = ($urandom % 4 == 0) ? 13'h0F0D : (($urandom % 2) ? 13'h0F0F : 13'h0F0E);
                access(a, 1'b1, "R1");
            end else if (r == 5) begin
                int k = $urandom % 7;
                a = (k < 5) ? kv(k) : ((k == 5) ? 13'h0F0F : 13'h0F0E);
                access(a, 1'b1, "R5");
            end else if (r == 6) begin
                access(13'($urandom), 1'b1, "R5");
            end else if (r == 7) begin
                access(kv($urandom % 5), 1'b0, "R4");
            end else if (r == 8) begin
                if (m_busy) finish_op("R7");
                else begin
                    @(negedge clk); op_done = 1'b1;
                    @(negedge clk); op_done = 1'b0;
                    check_outs("R10", 1'b0, 1'b0);
                end
            end else begin
                if (m_busy && ($urandom % 2)) finish_op("R7");
                else access(kv($urandom % 5), 1'b1, "R6");
            end
        end
        summary();
    end
endmodule